// File: doc/BRIEF.md
# SPI Byte-Addressed Memory Slave with Block Write Protection

This block is the serial front end of an on-chip byte memory. An external SPI master (mode 0) selects it with an active-low chip select, shifts in a one-byte command and, for memory accesses, a two-byte start address. Data bytes then stream at consecutive addresses for as long as the select stays low. There is no page buffer and no busy state. Each incoming data byte is committed to the array as soon as its eighth bit has been sampled.

Writes have two guards. A write-enable latch must be set by its own preceding transaction, and two block-protect bits in a status byte fence off the upper quarter, the upper half or the whole array. SCK, SI and the select are oversampled by the system clock, which must run at least four times faster than SCK. SO is only driven while read data or status is being shifted out. The array holds 2^ADDR_W bytes. ADDR_W=15 gives the full 32K configuration, and the default of 10 keeps elaboration small.

Top module: `spi_mem_slave`

## Requirements
- R1: Command codes are 01h status write, 02h memory write, 03h memory read, 04h write disable, 05h status read and 06h write enable. 06h sets the write-enable latch and 04h clears it. A status read returns the byte {0,1,0,0,BP1,BP0,WEL,0}, bit 7 first, repeated for as long as clocks continue.
- R2: A memory write command received while the write-enable latch is clear stores nothing.
- R3: Memory read and write commands take a two-byte start address, MSB first. Only the low ADDR_W bits select a location and the upper bits are ignored. Each following byte belongs to the next address.
- R4: The address counter wraps from the last location (3FFh by default) to 000h.
- R5: Each write data byte is stored after its eighth SCK rising edge, with no page limit. A read in the next transaction returns it.
- R6: The protect bits (BP1,BP0) select the protected range: 00 none, 01 upper quarter (300h–3FFh by default), 10 upper half (200h–3FFh), 11 everything.
- R7: A write burst whose start address is protected stores nothing. A burst that increments into a protected address stops storing from that address on.
- R8: A status write (data bits 3:2 → BP1,BP0) changes only the protect bits. It never changes WEL directly, and it is ignored while WEL is clear.
- R9: WEL clears when the select rises after an accepted memory write or status write that clocked at least one full data byte. Without a data byte, WEL stays set.
- R10: SO is driven (so_oe_o high) only while the slave is selected and shifting read data or status. Unknown command codes are ignored until the select rises.
- R11: Mode 0 timing applies. SI is sampled on SCK rising edges and SO changes after SCK falling edges, so the first read bit is valid before the first rising edge of the data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x SCK |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | SPI chip select, active low |
| sck_i | input | 1 | SPI serial clock |
| si_i | input | 1 | SPI serial data in |
| so_o | output | 1 | SPI serial data out |
| so_oe_o | output | 1 | Output enable for SO (low = high impedance) |

## Verification
The SCK, SI and select lines pass through a two-stage synchroniser and an edge detector. An SCK rising edge therefore takes effect three system clocks later, and the byte commit, command decode and address load all happen in that cycle. SO is updated three system clocks after an SCK falling edge, and a rising select clears the latch within four clocks. The bench holds each SCK phase for six system clocks and samples SO just before it raises SCK. It waits twelve clocks after releasing the select before it starts the next transaction, and it checks status and memory contents only through later read transactions.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef enum logic [3:0] {
    PH_CMD, PH_ADH, PH_ADL, PH_WDATA, PH_WBLK,
    PH_RDATA, PH_RDSR, PH_WRSR, PH_IDLE
  } phase_e;

  function automatic logic [7:0] status_byte(input logic [1:0] bp, input logic wel);
    return {4'b0100, bp, wel, 1'b0};
  endfunction
endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  output logic sel_o,
  output logic sel_end_o,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic si_o
);
  logic [STAGES-1:0] cs_sr, sck_sr, si_sr;
  logic cs_d, sck_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_sr  <= '1;
      sck_sr <= '0;
      si_sr  <= '0;
      cs_d   <= 1'b1;
      sck_d  <= 1'b0;
    end else begin
      cs_sr  <= {cs_sr[STAGES-2:0], cs_ni};
      sck_sr <= {sck_sr[STAGES-2:0], sck_i};
      si_sr  <= {si_sr[STAGES-2:0], si_i};
      cs_d   <= cs_sr[STAGES-1];
      sck_d  <= sck_sr[STAGES-1];
    end
  end

  assign sel_o      = ~cs_sr[STAGES-1];
  assign sel_end_o  = cs_sr[STAGES-1] & ~cs_d;
  assign sck_rise_o = sck_sr[STAGES-1] & ~sck_d;
  assign sck_fall_o = ~sck_sr[STAGES-1] & sck_d;
  assign si_o       = si_sr[STAGES-1];
endmodule

// File: rtl/spi_mem_guard.sv
module spi_mem_guard #(
  parameter int AW = 10
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    bp_i,
  output logic          prot_o
);
  always_comb begin
    unique case (bp_i)
      2'b00:   prot_o = 1'b0;
      2'b01:   prot_o = &addr_i[AW-1:AW-2];
      2'b10:   prot_o = addr_i[AW-1];
      default: prot_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  output logic so_o,
  output logic so_oe_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - 8;

  logic sel, sel_end, sck_rise, sck_fall, si_s;

  spi_mem_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .cs_ni, .sck_i, .si_i,
    .sel_o(sel), .sel_end_o(sel_end), .sck_rise_o(sck_rise),
    .sck_fall_o(sck_fall), .si_o(si_s)
  );

  phase_e            phase_q;
  logic [2:0]        bit_q;
  logic [6:0]        sh_q;
  logic [HI_W-1:0]   ahi_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q, wel_q, wr_seen_q, so_q;
  logic [1:0]        bp_q;
  logic [7:0]        tx_q;
  logic [7:0]        mem_q [DEPTH];

  logic [7:0]        rx_byte;
  logic              byte_done, mem_we, prot_start, prot_next;
  logic [ADDR_W-1:0] addr_ld, addr_nxt;

  assign rx_byte   = {sh_q, si_s};
  assign byte_done = sel & sck_rise & (bit_q == 3'd7);
  assign addr_ld   = {ahi_q, rx_byte};
  assign addr_nxt  = addr_q + ADDR_W'(1);
  assign mem_we    = byte_done & (phase_q == PH_WDATA);

  // start address and the one after the current byte are checked in parallel
  spi_mem_guard #(.AW(ADDR_W)) u_guard_start (.addr_i(addr_ld),  .bp_i(bp_q), .prot_o(prot_start));
  spi_mem_guard #(.AW(ADDR_W)) u_guard_next  (.addr_i(addr_nxt), .bp_i(bp_q), .prot_o(prot_next));

  always_ff @(posedge clk_i) begin
    if (mem_we) mem_q[addr_q] <= rx_byte;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_CMD;
      bit_q     <= '0;
      sh_q      <= '0;
      ahi_q     <= '0;
      addr_q    <= '0;
      rd_q      <= 1'b0;
      wel_q     <= 1'b0;
      wr_seen_q <= 1'b0;
      bp_q      <= '0;
      tx_q      <= '0;
      so_q      <= 1'b0;
    end else if (!sel) begin
      if (sel_end && wr_seen_q) wel_q <= 1'b0;
      phase_q   <= PH_CMD;
      bit_q     <= '0;
      wr_seen_q <= 1'b0;
    end else begin
      if (sck_rise) begin
        bit_q <= bit_q + 3'd1;
        sh_q  <= {sh_q[5:0], si_s};
      end
      if (sck_fall) begin
        so_q <= tx_q[7];
        tx_q <= {tx_q[6:0], 1'b0};
      end
      if (byte_done) begin
        unique case (phase_q)
          PH_CMD: begin
            unique case (rx_byte)
              OP_WREN:  begin wel_q <= 1'b1; phase_q <= PH_IDLE; end
              OP_WRDI:  begin wel_q <= 1'b0; phase_q <= PH_IDLE; end
              OP_RDSR:  begin tx_q <= status_byte(bp_q, wel_q); phase_q <= PH_RDSR; end
              OP_READ:  begin rd_q <= 1'b1; phase_q <= PH_ADH; end
              OP_WRITE: begin rd_q <= 1'b0; phase_q <= wel_q ? PH_ADH : PH_IDLE; end
              OP_WRSR:  phase_q <= wel_q ? PH_WRSR : PH_IDLE;
              default:  phase_q <= PH_IDLE;
            endcase
          end
          PH_ADH: begin
            ahi_q   <= rx_byte[HI_W-1:0];
            phase_q <= PH_ADL;
          end
          PH_ADL: begin
            addr_q <= addr_ld;
            if (rd_q) begin
              tx_q    <= mem_q[addr_ld];
              phase_q <= PH_RDATA;
            end else begin
              phase_q <= prot_start ? PH_WBLK : PH_WDATA;
            end
          end
          PH_WDATA: begin
            addr_q    <= addr_nxt;
            wr_seen_q <= 1'b1;
            if (prot_next) phase_q <= PH_WBLK;
          end
          PH_WBLK:  wr_seen_q <= 1'b1;
          PH_RDATA: begin
            addr_q <= addr_nxt;
            tx_q   <= mem_q[addr_nxt];
          end
          PH_RDSR:  tx_q <= status_byte(bp_q, wel_q);
          PH_WRSR: begin
            bp_q      <= rx_byte[3:2];
            wr_seen_q <= 1'b1;
            phase_q   <= PH_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  assign so_oe_o = sel & ((phase_q == PH_RDATA) | (phase_q == PH_RDSR));
  assign so_o    = so_q;
endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              so_oe_i,
  input logic              wel_i,
  input logic [1:0]        bp_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] waddr_i
);
  a_r10_so_only_when_selected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_oe_i |-> sel_i);

  a_r2_store_needs_wel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> wel_i);

  a_r7_no_store_in_protected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> !((bp_i == 2'b11) ||
               (bp_i == 2'b10 && waddr_i[ADDR_W-1]) ||
               (bp_i == 2'b01 && waddr_i[ADDR_W-1] && waddr_i[ADDR_W-2])));

  a_r8_bp_change_keeps_wel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bp_i != $past(bp_i)) |-> (wel_i == $past(wel_i)));

  a_r8_bp_change_needs_wel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bp_i != $past(bp_i)) |-> $past(wel_i));

  a_r10_no_drive_while_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |-> !so_oe_i);
endmodule

bind spi_mem_slave spi_mem_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sel_i   (sel),
  .so_oe_i (so_oe_o),
  .wel_i   (wel_q),
  .bp_i    (bp_q),
  .we_i    (mem_we),
  .waddr_i (addr_q)
);

// File: tb/spi_mem_slave_test.sv
module spi_mem_slave_test;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = 6;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic so, so_oe;

  int checks = 0, errors = 0;
  logic [7:0] model [DEPTH];
  bit         model_v [DEPTH];
  logic [1:0] bp_m = 2'b00;
  logic       wel_m = 1'b0;
  bit         oe_seen;
  logic [7:0] wbuf [16];
  logic [7:0] rx, st;

  always #10 clk = ~clk;

  spi_mem_slave #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
    .so_o(so), .so_oe_o(so_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      si = tx[i];
      tick(HALF);
      r[i] = so;
      if (so_oe) oe_seen = 1'b1;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic sel_on();
    cs_n = 1'b0;
    tick(HALF);
  endtask

  task automatic sel_off();
    tick(HALF);
    cs_n = 1'b1;
    tick(2 * HALF);
  endtask

  function automatic bit prot(input int a);
    case (bp_m)
      2'b00:   return 1'b0;
      2'b01:   return a >= (DEPTH * 3) / 4;
      2'b10:   return a >= DEPTH / 2;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] exp_status();
    return {4'b0100, bp_m, wel_m, 1'b0};
  endfunction

  task automatic op(input logic [7:0] code);
    logic [7:0] r;
    sel_on(); xfer(code, r); sel_off();
    if (code == 8'h06) wel_m = 1'b1;
    if (code == 8'h04) wel_m = 1'b0;
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] r;
    sel_on(); xfer(8'h05, r); xfer(8'h00, s); sel_off();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r;
    sel_on(); xfer(8'h01, r); xfer(v, r); sel_off();
    if (wel_m) begin
      bp_m  = v[3:2];
      wel_m = 1'b0;
    end
  endtask

  task automatic wr(input logic [15:0] a, input int n);
    logic [7:0] r;
    int cur;
    bit blocked;
    sel_on();
    xfer(8'h02, r); xfer(a[15:8], r); xfer(a[7:0], r);
    for (int i = 0; i < n; i++) xfer(wbuf[i], r);
    sel_off();
    if (wel_m) begin
      cur = int'(a) % DEPTH;
      blocked = 1'b0;
      for (int i = 0; i < n; i++) begin
        if (prot(cur)) blocked = 1'b1;
        if (!blocked) begin
          model[cur]   = wbuf[i];
          model_v[cur] = 1'b1;
        end
        cur = (cur + 1) % DEPTH;
      end
      if (n > 0) wel_m = 1'b0;
    end
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a, input int n);
    logic [7:0] r;
    int cur;
    sel_on();
    xfer(8'h03, r); xfer(a[15:8], r); xfer(a[7:0], r);
    cur = int'(a) % DEPTH;
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, r);
      if (model_v[cur]) chk8(req, r, model[cur]);
      cur = (cur + 1) % DEPTH;
    end
    sel_off();
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R10: idle after reset, SO not driven
    chk8("R10 reset oe", {7'b0, so_oe}, 8'h00);
    rdsr(st); chk8("R1 reset status", st, 8'h40);
    op(8'h06); rdsr(st); chk8("R1 WREN status", st, exp_status());
    op(8'h04); rdsr(st); chk8("R1 WRDI status", st, exp_status());

    // preload regions near every protection boundary
    op(8'h06); fill(16); wr(16'h0000, 16);
    op(8'h06); fill(16); wr(16'h01F8, 16);
    op(8'h06); fill(16); wr(16'h02F8, 16);
    op(8'h06); fill(16); wr(16'h03F0, 16);
    rd_chk("R5 R11 readback", 16'h0000, 16);
    rd_chk("R5 R11 readback", 16'h02F8, 16);

    // R2: no WREN, nothing stored
    fill(4); wr(16'h0000, 4);
    rd_chk("R2 write without WEL", 16'h0000, 4);

    // R4: wrap from last location
    op(8'h06); fill(4); wr(16'h03FE, 4);
    rd_chk("R4 wrap", 16'h03FE, 4);

    // R3: upper address bits ignored
    op(8'h06); fill(3); wr(16'hFC05, 3);
    rd_chk("R3 upper bits", 16'h0005, 3);

    // R8, R9: status write
    op(8'h06); wrsr(8'hFF); rdsr(st); chk8("R8 R9 wrsr all ones", st, exp_status());
    wrsr(8'h00); rdsr(st); chk8("R8 wrsr without WEL", st, 8'h4C);
    op(8'h06); rdsr(st); chk8("R8 WEL set", st, 8'h4E);
    wrsr(8'h02); rdsr(st); chk8("R9 WEL cleared by wrsr", st, 8'h40);

    // R6, R7: upper quarter
    op(8'h06); wrsr(8'h04); rdsr(st); chk8("R6 bp quarter", st, 8'h44);
    op(8'h06); fill(4); wr(16'h02FE, 4);
    rdsr(st); chk8("R9 WEL cleared by write", st, 8'h44);
    rd_chk("R7 burst into quarter", 16'h02FC, 8);
    op(8'h06); fill(2); wr(16'h0300, 2);
    rd_chk("R7 start protected", 16'h02FE, 6);

    // R6: upper half
    op(8'h06); wrsr(8'h08);
    op(8'h06); fill(4); wr(16'h01FE, 4);
    rd_chk("R6 half", 16'h01FC, 8);
    op(8'h06); fill(2); wr(16'h02FA, 2);
    rd_chk("R6 half upper", 16'h02FA, 2);

    // R6: everything
    op(8'h06); wrsr(8'h0C);
    op(8'h06); fill(4); wr(16'h0000, 4);
    rd_chk("R6 all", 16'h0000, 4);

    // R9: write command with no data keeps WEL
    op(8'h06); wr(16'h0010, 0);
    rdsr(st); chk8("R9 no data byte", st, exp_status());
    op(8'h04);
    op(8'h06); wrsr(8'h00);

    // R10: unknown command and write never drive SO
    oe_seen = 1'b0;
    sel_on(); xfer(8'hAB, rx); xfer(8'h03, rx); xfer(8'h00, rx); xfer(8'h00, rx); sel_off();
    chk8("R10 unknown cmd oe", {7'b0, oe_seen}, 8'h00);
    rdsr(st); chk8("R10 unknown cmd status", st, exp_status());
    oe_seen = 1'b0;
    op(8'h06); fill(2); wr(16'h0020, 2);
    chk8("R10 write oe", {7'b0, oe_seen}, 8'h00);
    oe_seen = 1'b0;
    rdsr(st);
    chk8("R10 status oe", {7'b0, oe_seen}, 8'h01);

    // R1: status repeats while clocked
    sel_on(); xfer(8'h05, rx); xfer(8'h00, rx); xfer(8'h00, st); sel_off();
    chk8("R1 repeated status", st, exp_status());

    // R5, R3: random bursts, no protection
    for (int k = 0; k < 20; k++) begin
      int a, n;
      a = int'($urandom % DEPTH);
      n = 1 + int'($urandom % 6);
      op(8'h06); fill(n); wr(16'(a), n);
      rd_chk("R5 random burst", 16'(a), n);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule